// File: doc/BRIEF.md
# SPI Master with Chained-Frame Chip Select

This block is an SPI master for mode 0 (clock idles low). It takes bytes from an eight-entry transmit queue, shifts them out MSB first on the data-out pin, and collects the bits it samples from the data-in pin into bytes in an eight-entry receive queue. The serial clock runs at the system clock divided by 2×(DIV+1), and DIV is an 8-bit input.

A single active-low chip select frames each transfer. With frame hold enabled, chip select falls when the first queued byte starts and stays low while bytes keep arriving in the queue. There is no gap between bytes. It rises only once the queue is empty and the last bit has left. A chain of cascaded shift-register slaves (master output into the first slave, each slave's output into the next, the last slave back to the master input) therefore sees one continuous frame. For example, eight writes give 64 clocks, enough to load four chained 16-bit slaves, and the slaves latch on the rising chip select. With frame hold disabled, every byte gets its own chip-select window.

Top module: `spi_chain_master`

## Requirements
- R1: The serial clock is low whenever chip select is high. Data out is the MSB of the current byte and changes only while the clock falls or chip select falls. It never changes while the clock is high.
- R2: Data in is sampled on each rising clock edge and assembled MSB first. Received bytes are read oldest first: `rx_avail` is 1 when the receive queue holds a byte, `rx_data` shows the oldest byte, and a one-cycle `rx_rd` removes it.
- R3: Every clock half-period lasts DIV+1 system clocks. The time from chip select falling to the first rising clock edge is one half-period. The time from the last falling clock edge to chip select rising is also one half-period.
- R4: With `hold_en`=1, chip select stays low across all back-to-back queued bytes. The window contains exactly 8 clocks per byte, so eight writes produce 64 clocks in one window and load a four-deep chain of 16-bit slaves.
- R5: With `hold_en`=0, each byte has its own chip-select window of exactly 8 clocks. Chip select stays high for at least two half-periods between windows.
- R6: After any window ends, chip select stays high for at least two half-periods before the next window begins, even when new bytes are written while it is high.
- R7: `busy` is 0 after reset and when idle, and is 1 whenever chip select is low.
- R8: The transmit queue holds 8 bytes. A write while `tx_full`=1 is discarded and sets `tx_ovf`, which stays 1 until reset.
- R9: A received byte that arrives while the receive queue holds 8 unread bytes is discarded.
- R10: After reset, chip select is high, the clock is low, and `busy`, `rx_avail` and `tx_ovf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div | input | 8 | Clock divider: half-period is div+1 system clocks |
| hold_en | input | 1 | 1 = keep chip select low while bytes remain queued |
| tx_wr | input | 1 | Write strobe for one transmit byte |
| tx_data | input | 8 | Transmit byte |
| tx_full | output | 1 | Transmit queue holds 8 bytes |
| tx_ovf | output | 1 | Sticky flag for a discarded write |
| rx_rd | input | 1 | Removes the oldest received byte |
| rx_data | output | 8 | Oldest received byte |
| rx_avail | output | 1 | Receive queue not empty |
| busy | output | 1 | A frame or its trailing guard time is in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench drives a model of four chained 16-bit slaves and checks three things: the count of clocks in each chip-select window (a design that splits a held frame into bytes would show windows of 8), the slave contents latched on the rising chip select, and the bytes read back from the chain. It measures every interval between chip-select and clock edges against DIV+1, including the case DIV=0. This catches a missing setup or trailing half-period, or an off-by-one divider. It refills the queue while chip select is high, to catch a design that starts the next frame without a high gap. It writes ten bytes into a filling queue and checks that exactly one write is dropped and flagged, and that the ninth received byte is lost because the receive queue is full.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SHIFT,
        ST_TRAIL,
        ST_GAP
    } eng_state_t;

endpackage

// File: rtl/spi_chain_fifo.sv
module spi_chain_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } fifo_regs_t;

    fifo_regs_t r_q, r_d;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        r_d     = r_q;
        do_push = push && (r_q.cnt != CAP);
        do_pop  = pop && (r_q.cnt != '0);
        if (do_push) r_d.wr = (r_q.wr == LAST) ? '0 : r_q.wr + 1'b1;
        if (do_pop)  r_d.rd = (r_q.rd == LAST) ? '0 : r_q.rd + 1'b1;
        case ({do_push, do_pop})
            2'b10:   r_d.cnt = r_q.cnt + 1'b1;
            2'b01:   r_d.cnt = r_q.cnt - 1'b1;
            default: r_d.cnt = r_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[r_q.wr] <= push_data;
    end

    assign head  = mem_q[r_q.rd];
    assign empty = (r_q.cnt == '0);
    assign full  = (r_q.cnt == CAP);

    AST_FIFO_FULL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);   // R8
    AST_FIFO_EMPTY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty); // R2
endmodule

// File: rtl/spi_chain_engine.sv
module spi_chain_engine
    import spi_chain_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div,
    input  logic              hold_en,
    input  logic              tx_avail,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_byte,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n,
    output logic              busy
);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
    localparam logic [BIT_W-1:0] ONE_BIT  = BIT_W'(1);

    typedef struct packed {
        eng_state_t        st;
        logic [DIV_W-1:0]  cnt;
        logic [BIT_W-1:0]  bits;
        logic [DATA_W-1:0] tx_sh;
        logic [DATA_W-1:0] rx_sh;
        logic              sclk;
        logic              cs_n;
    } eng_regs_t;

    localparam eng_regs_t RESET_V = '{st: ST_IDLE, cnt: '0, bits: '0,
                                      tx_sh: '0, rx_sh: '0, sclk: 1'b0, cs_n: 1'b1};

    eng_regs_t r_q, r_d;
    logic tick;

    always_comb begin
        r_d     = r_q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        tick    = (r_q.cnt >= div);
        if (r_q.st != ST_IDLE) r_d.cnt = tick ? '0 : r_q.cnt + 1'b1;
        case (r_q.st)
            ST_IDLE: begin
                r_d.cnt  = '0;
                r_d.sclk = 1'b0;
                if (tx_avail) begin
                    tx_pop    = 1'b1;
                    r_d.tx_sh = tx_byte;
                    r_d.bits  = '0;
                    r_d.cs_n  = 1'b0;
                    r_d.st    = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (tick) begin
                    r_d.sclk  = 1'b1;
                    r_d.rx_sh = {r_q.rx_sh[DATA_W-2:0], miso};
                    r_d.st    = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!r_q.sclk) begin
                        r_d.sclk  = 1'b1;
                        r_d.rx_sh = {r_q.rx_sh[DATA_W-2:0], miso};
                    end else begin
                        r_d.sclk = 1'b0;
                        if (r_q.bits == LAST_BIT) begin
                            rx_push = 1'b1;
                            if (hold_en && tx_avail) begin
                                tx_pop    = 1'b1;
                                r_d.tx_sh = tx_byte;
                                r_d.bits  = '0;
                            end else begin
                                r_d.st = ST_TRAIL;
                            end
                        end else begin
                            r_d.bits  = r_q.bits + 1'b1;
                            r_d.tx_sh = {r_q.tx_sh[DATA_W-2:0], 1'b0};
                        end
                    end
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    r_d.cs_n = 1'b1;
                    r_d.bits = '0;
                    r_d.st   = ST_GAP;
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (r_q.bits == ONE_BIT) r_d.st = ST_IDLE;
                    else                     r_d.bits = ONE_BIT;
                end
            end
            default: r_d = RESET_V;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_V;
        else        r_q <= r_d;
    end

    assign rx_byte = r_q.rx_sh;
    assign mosi    = r_q.tx_sh[DATA_W-1];
    assign sclk    = r_q.sclk;
    assign cs_n    = r_q.cs_n;
    assign busy    = (r_q.st != ST_IDLE);

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);                          // R1
    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi)); // R1
    AST_BUSY_COVERS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);                          // R7
    AST_CS_FALL_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(tx_avail));         // R6
endmodule

// File: rtl/spi_chain_master.sv
module spi_chain_master
    import spi_chain_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div,
    input  logic              hold_en,
    input  logic              tx_wr,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_full,
    output logic              tx_ovf,
    input  logic              rx_rd,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_avail,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    logic              tx_empty, tx_pop, rx_push, rx_empty, rx_full;
    logic [BYTE_W-1:0] tx_head, rx_byte;
    logic              ovf_q, ovf_d;

    spi_chain_fifo #(.W(BYTE_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push(tx_wr), .push_data(tx_data),
        .pop(tx_pop), .head(tx_head),
        .empty(tx_empty), .full(tx_full)
    );

    spi_chain_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .push_data(rx_byte),
        .pop(rx_rd), .head(rx_data),
        .empty(rx_empty), .full(rx_full)
    );

    spi_chain_engine #(.DIV_W(DIV_W), .DATA_W(BYTE_W)) u_eng (
        .clk(clk), .rst_n(rst_n),
        .div(div), .hold_en(hold_en),
        .tx_avail(!tx_empty), .tx_byte(tx_head), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_byte(rx_byte),
        .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy)
    );

    always_comb begin
        ovf_d = ovf_q | (tx_wr & tx_full);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= ovf_d;
    end

    assign tx_ovf   = ovf_q;
    assign rx_avail = !rx_empty;

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovf |=> tx_ovf);                       // R8
    AST_OVF_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_full) |=> tx_ovf);           // R8
    AST_RX_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !rx_rd) |=> !rx_empty);       // R9
endmodule

// File: tb/spi_chain_master_bench.sv
module spi_chain_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div = 8'd1;
    logic       hold_en = 1'b0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       rx_rd = 1'b0;
    logic       miso;
    wire        tx_full, tx_ovf, rx_avail, busy, sclk, mosi, cs_n;
    wire  [7:0] rx_data;

    spi_chain_master u_spi_chain_master (
        .clk(clk), .rst_n(rst_n), .div(div), .hold_en(hold_en),
        .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full), .tx_ovf(tx_ovf),
        .rx_rd(rx_rd), .rx_data(rx_data), .rx_avail(rx_avail), .busy(busy),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;

    // reference state
    logic [15:0] slv [4];
    logic [15:0] latched [4];
    logic        cap [4];
    bit          exp_mosi [$];
    int          exp_win [$];
    logic [7:0]  rx_model [$];
    logic [7:0]  rx_acc;
    int          rx_nbits = 0;
    int          half = 2;

    // monitor state
    logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_mosi = 1'b0;
    int   ev_cnt = 0, rises = 0, cs_high_cnt = 0;
    bit   seen_win = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WATCHDOG && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    assign miso = slv[3][15];

    // cycle-by-cycle pin monitor and chained-slave model
    always @(negedge clk) begin
        if (rst_n) begin
            ev_cnt++;
            if (prev_cs && !cs_n) begin
                if (seen_win)
                    check(cs_high_cnt + 1 >= 2 * half, hold_en ? "R6" : "R5",
                          "cs high gap", cs_high_cnt + 1, 2 * half);
                seen_win = 1;
                ev_cnt = 0;
                rises = 0;
            end
            if (sclk != prev_sclk) begin
                if (cs_n) check(0, "R1", "sclk toggled with cs high", 1, 0);
                check(ev_cnt == half, "R3", "half period", ev_cnt, half);
                ev_cnt = 0;
            end
            if (sclk && !prev_sclk) begin
                rises++;
                if (exp_mosi.size() == 0) check(0, "R1", "unexpected bit", 1, 0);
                else begin
                    bit e;
                    e = exp_mosi.pop_front();
                    check(mosi == e, "R1", "mosi bit", mosi, e);
                end
                cap[0] = mosi;
                for (int k = 1; k < 4; k++) cap[k] = slv[k-1][15];
                rx_acc = {rx_acc[6:0], slv[3][15]};
                rx_nbits++;
                if (rx_nbits == 8) begin
                    rx_nbits = 0;
                    if (rx_model.size() < 8) rx_model.push_back(rx_acc); // R9
                end
            end
            if (!sclk && prev_sclk) begin
                for (int k = 0; k < 4; k++) slv[k] = {slv[k][14:0], cap[k]};
            end
            if (sclk && prev_sclk && mosi != prev_mosi)
                check(0, "R1", "mosi moved while sclk high", mosi, prev_mosi);
            if (!prev_cs && cs_n) begin
                int w;
                check(ev_cnt == half, "R3", "trail to cs rise", ev_cnt, half);
                w = (exp_win.size() != 0) ? exp_win.pop_front() : -1;
                check(rises == w, hold_en ? "R4" : "R5", "clocks in window", rises, w);
                for (int k = 0; k < 4; k++) latched[k] = slv[k];
                cs_high_cnt = 0;
            end else if (cs_n) begin
                cs_high_cnt++;
            end
            if (!cs_n && !busy) check(0, "R7", "busy low while cs low", busy, 1);
            prev_cs   = cs_n;
            prev_sclk = sclk;
            prev_mosi = mosi;
        end
    end

    task automatic write_byte(input logic [7:0] b, input bit accepted);
        tx_wr   = 1'b1;
        tx_data = b;
        if (accepted) for (int i = 7; i >= 0; i--) exp_mosi.push_back(b[i]);
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic read_rx(input logic [7:0] exp, input string req);
        check(rx_avail == 1'b1, req, "rx_avail before read", rx_avail, 1);
        check(rx_data == exp, req, "rx byte", rx_data, exp);
        if (rx_model.size() != 0) void'(rx_model.pop_front());
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 4) begin
            @(negedge clk);
            quiet = busy ? 0 : quiet + 1;
        end
        check(exp_win.size() == 0, "R4", "windows outstanding", exp_win.size(), 0);
        check(exp_mosi.size() == 0, "R1", "bits outstanding", exp_mosi.size(), 0);
    endtask

    initial begin
        logic [7:0] frame [8];
        slv[3] = 16'hA1B2; slv[2] = 16'hC3D4; slv[1] = 16'hE5F6; slv[0] = 16'h0718;
        for (int k = 0; k < 4; k++) begin cap[k] = 1'b0; latched[k] = 16'h0; end
        rx_acc = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        check(cs_n == 1'b1, "R10", "cs_n after reset", cs_n, 1);
        check(sclk == 1'b0, "R10", "sclk after reset", sclk, 0);
        check(busy == 1'b0, "R10", "busy after reset", busy, 0);
        check(rx_avail == 1'b0, "R10", "rx_avail after reset", rx_avail, 0);
        check(tx_ovf == 1'b0, "R10", "tx_ovf after reset", tx_ovf, 0);

        // R4: 64-clock held frame into four chained 16-bit slaves
        div = 8'd1; half = 2; hold_en = 1'b1;
        frame = '{8'h3C, 8'h96, 8'h0F, 8'hE1, 8'h72, 8'hAB, 8'h44, 8'hD8};
        exp_win.push_back(64);
        for (int i = 0; i < 8; i++) write_byte(frame[i], 1);
        wait_idle();
        check(latched[3] == 16'h3C96, "R4", "slave3 latched", latched[3], 16'h3C96);
        check(latched[2] == 16'h0FE1, "R4", "slave2 latched", latched[2], 16'h0FE1);
        check(latched[1] == 16'h72AB, "R4", "slave1 latched", latched[1], 16'h72AB);
        check(latched[0] == 16'h44D8, "R4", "slave0 latched", latched[0], 16'h44D8);
        // R2: previous chain contents come back MSB first, oldest byte first
        read_rx(8'hA1, "R2"); read_rx(8'hB2, "R2");
        read_rx(8'hC3, "R2"); read_rx(8'hD4, "R2");
        read_rx(8'hE5, "R2"); read_rx(8'hF6, "R2");
        read_rx(8'h07, "R2"); read_rx(8'h18, "R2");
        check(rx_avail == 1'b0, "R2", "rx empty after reads", rx_avail, 0);

        // R5: per-byte windows with hold disabled, fastest divider
        div = 8'd0; half = 1; hold_en = 1'b0;
        exp_win.push_back(8); exp_win.push_back(8); exp_win.push_back(8);
        write_byte(8'h5A, 1); write_byte(8'hC1, 1); write_byte(8'h80, 1);
        wait_idle();
        for (int i = 0; i < 3; i++) read_rx(rx_model[0], "R5");
        check(busy == 1'b0, "R7", "busy idle", busy, 0);

        // R8/R9: overflow of TX queue; 9 bytes accepted, 9th RX byte dropped
        div = 8'd3; half = 4; hold_en = 1'b1;
        exp_win.push_back(72);
        for (int i = 0; i < 10; i++) write_byte(8'(8'h11 * (i + 1)), i < 9);
        check(tx_ovf == 1'b1, "R8", "tx_ovf set on drop", tx_ovf, 1);
        wait_idle();
        check(tx_ovf == 1'b1, "R8", "tx_ovf sticky", tx_ovf, 1);
        check(rx_model.size() == 8, "R9", "model rx count", rx_model.size(), 8);
        for (int i = 0; i < 8; i++) read_rx(rx_model[0], "R9");
        check(rx_avail == 1'b0, "R9", "ninth byte discarded", rx_avail, 0);

        // R6: refill right as cs rises; next frame must wait out the gap
        div = 8'd0; half = 1; hold_en = 1'b1;
        exp_win.push_back(16); exp_win.push_back(16);
        write_byte(8'hF0, 1); write_byte(8'h0F, 1);
        @(posedge cs_n);
        @(negedge clk);
        write_byte(8'hA5, 1); write_byte(8'h3E, 1);
        wait_idle();
        for (int i = 0; i < 4; i++) read_rx(rx_model[0], "R6");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule